// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block holds radio calibration results for several receive chains so that a later retune can put them back without running the calibration again. Each chain owns a six-entry table of 28-bit words. By entry number, the table holds three DC-offset DAC settings (loop, low, high), the filter cutoff, the receive gain setting and the peak-detector offset. Software reaches the tables only indirectly. It loads a per-chain data register, writes a per-chain command word and sets a go flag. The go flag clears itself when the operation has finished.

A control register enables retention and holds a six-bit restore mask with one bit per entry. It also holds a force bit. Setting the force bit with retention enabled starts a restore pass. The pass walks entries 0 to 5, one per clock. For every entry whose mask bit is set, it presents that entry of every chain on the restore outputs. The force bit clears itself when the pass ends. Table accesses and restore passes never overlap. A go flag raised during a restore waits until the pass has finished.

The register bus has one address, one strobe, one write-enable, one write-data and one read-data signal. Writes take effect at the clock edge where the strobe is high. Read data is combinational while the strobe is high with write-enable low. The word addresses are: control at 0, chain c command at 1+2c, chain c data at 2+2c.

Top module: `cal_keep_store`

## Requirements
- R1: After reset, the control register, every command register, every data register and every table entry read as zero, and `rs_valid` is low.
- R2: The control register has retention enable at bit 0, restore mask bits 6:1 (bit k+1 selects entry k) and force at bit 7. Enable and mask read back as written. A write that sets force while the enable bit being written is 0 starts no restore, and force reads 0.
- R3: A write that sets force with enable 1 makes force read 1 for exactly six cycles, starting with the cycle after the write edge, and then read 0. Control writes during those six cycles are ignored.
- R4: In restore cycle k (k = 0..5), `rs_index` equals k. `rs_valid` is high exactly when mask bit k is set, and chain c's slice of `rs_data` (bits c*28 upward) equals entry k of chain c. Outside a restore, `rs_valid` is low.
- R5: A command word has go at bit 0, write (1) or read (0) at bit 1, and the entry index at bits 4:2. The data register carries the entry in bits 31:4, with bits 3:0 reading 0. A write operation stores the data register into the indexed entry. Go reads 1 in the cycle after it is set and 0 one cycle later.
- R6: After a read operation's go flag clears, the data register holds the indexed entry.
- R7: A write with index 6 or 7 changes no entry. A read with index 6 or 7 loads zero into the data register.
- R8: A go set during a restore stays 1 until the pass has ended, and the operation then completes one cycle later. Writes to a chain's command or data register while its go flag is 1 are ignored.
- R9: An operation on one chain leaves every other chain's table and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rs_valid | output | 1 | Restore entry presented this cycle |
| rs_index | output | 3 | Entry number being restored |
| rs_data | output | 84 | Entry value, 28 bits per chain, chain 0 lowest |

## Verification
A step counter that drifts during a restore would show up at once. `rs_index` would skip or repeat a value, or the force bit would stay high for a number of cycles other than six, so the fault appears within the same pass. A go flag stuck high, or an operation that runs during a restore, is seen on the command register read one or two cycles after the go. A write to the wrong entry or to the wrong chain stays hidden until that entry is read back or restored. For that reason, every entry of every chain is read back and also restored under several masks.

// File: rtl/cal_keep_store.sv
module cal_keep_store #(
  parameter int NCH  = 3,
  parameter int NENT = 6,
  parameter int AW   = 4,
  parameter int BW   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_stb,
  input  logic                  bus_we,
  input  logic [BW-1:0]         bus_wdata,
  output logic [BW-1:0]         bus_rdata,
  output logic                  rs_valid,
  output logic [$clog2(NENT)-1:0] rs_index,
  output logic [NCH*(BW-4)-1:0] rs_data
);
  localparam int DW   = BW - 4;
  localparam int IW   = $clog2(NENT);
  localparam int FBIT = NENT + 1;
  localparam logic [IW-1:0] LAST = IW'(NENT - 1);

  logic            en;
  logic [NENT-1:0] mask;
  logic            restoring;
  logic [IW-1:0]   ptr;

  logic [NCH-1:0]  go;
  logic [NCH-1:0]  wr;
  logic [IW-1:0]   idx  [NCH];
  logic [DW-1:0]   dreg [NCH];
  logic [DW-1:0]   tbl  [NCH][NENT];

  logic bus_wr;
  logic ctrl_wr;
  assign bus_wr  = bus_stb && bus_we;
  assign ctrl_wr = bus_wr && (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      mask      <= '0;
      restoring <= 1'b0;
      ptr       <= '0;
    end else if (restoring) begin
      if (ptr == LAST) begin
        restoring <= 1'b0;
        ptr       <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (ctrl_wr) begin
      en        <= bus_wdata[0];
      mask      <= bus_wdata[NENT:1];
      restoring <= bus_wdata[FBIT] && bus_wdata[0];
      ptr       <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        go[c]   <= 1'b0;
        wr[c]   <= 1'b0;
        idx[c]  <= '0;
        dreg[c] <= '0;
        for (int e = 0; e < NENT; e++) tbl[c][e] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (go[c]) begin
          if (!restoring) begin
            go[c] <= 1'b0;
            if (wr[c]) begin
              for (int e = 0; e < NENT; e++)
                if (idx[c] == IW'(e)) tbl[c][e] <= dreg[c];
            end else begin
              dreg[c] <= '0;
              for (int e = 0; e < NENT; e++)
                if (idx[c] == IW'(e)) dreg[c] <= tbl[c][e];
            end
          end
        end else begin
          if (bus_wr && bus_addr == AW'(1 + 2*c)) begin
            go[c]  <= bus_wdata[0];
            wr[c]  <= bus_wdata[1];
            idx[c] <= bus_wdata[2 +: IW];
          end
          if (bus_wr && bus_addr == AW'(2 + 2*c))
            dreg[c] <= bus_wdata[BW-1:4];
        end
      end
    end
  end

  assign rs_valid = restoring && mask[ptr];
  assign rs_index = ptr;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_rs
      assign rs_data[c*DW +: DW] = restoring ? tbl[c][ptr] : '0;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_stb && !bus_we) begin
      if (bus_addr == '0)
        bus_rdata = BW'({restoring, mask, en});
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == AW'(1 + 2*c))
          bus_rdata = BW'({idx[c], wr[c], go[c]});
        if (bus_addr == AW'(2 + 2*c))
          bus_rdata = {dreg[c], 4'b0000};
      end
    end
  end

  AST_FORCE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    restoring |-> en);  // R2
  AST_RESTORE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (restoring && ptr == LAST) |=> !restoring);  // R3
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (restoring && ptr != LAST) |=> (restoring && ptr == IW'($past(ptr) + 1'b1)));  // R4
  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    !restoring |-> (ptr == '0 && !rs_valid));  // R4

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ast
      AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (restoring && go[c]) |=> go[c]);  // R8
      AST_GO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restoring && go[c]) |=> !go[c]);  // R5
    end
  endgenerate
endmodule

// File: tb/sim_cal_keep_store.sv
module sim_cal_keep_store;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int NENT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_stb = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rs_valid;
  logic [2:0]  rs_index;
  logic [NCH*28-1:0] rs_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [27:0] mdl [NCH][NENT];

  cal_keep_store u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rs_valid(rs_valid), .rs_index(rs_index), .rs_data(rs_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1; bus_stb = 1'b1;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = 4'(a); bus_we = 1'b0; bus_stb = 1'b1;
    #1 v = bus_rdata;
    bus_stb = 1'b0;
  endtask

  function automatic logic [31:0] cmdw(input int i, input bit w, input bit g);
    return {27'd0, 3'(i), w, g};
  endfunction

  task automatic put_entry(input int c, input int i, input logic [27:0] d);
    logic [31:0] v;
    wr(2 + 2*c, {d, 4'h0});
    wr(1 + 2*c, cmdw(i, 1, 0));
    wr(1 + 2*c, cmdw(i, 1, 1));
    rd(1 + 2*c, v); check("R5 go set", v, cmdw(i, 1, 1));
    tick();
    rd(1 + 2*c, v); check("R5 go cleared", v, cmdw(i, 1, 0));
    if (i < NENT) mdl[c][i] = d;
  endtask

  task automatic get_entry(input int c, input int i, output logic [31:0] v);
    wr(1 + 2*c, cmdw(i, 0, 0));
    wr(1 + 2*c, cmdw(i, 0, 1));
    tick();
    rd(2 + 2*c, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); check("R1 ctrl", v, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(1 + 2*c, v); check("R1 cmd", v, 0);
      rd(2 + 2*c, v); check("R1 data", v, 0);
    end
    check("R1 rs_valid", 32'(rs_valid), 0);
    get_entry(2, 5, v); check("R1 entry", v, 0);
  endtask

  task automatic t_access();
    logic [31:0] v;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < NENT; i++)
        put_entry(c, i, 28'(32'h0A00000 * (c + 1) + 32'h13579 * (i + 1)));
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < NENT; i++) begin
        get_entry(c, i, v);
        check("R6 readback", v, {mdl[c][i], 4'h0});
      end
    put_entry(1, 3, 28'hFFFFFFF);
    get_entry(0, 3, v); check("R9 chain0 untouched", v, {mdl[0][3], 4'h0});
    get_entry(2, 3, v); check("R9 chain2 untouched", v, {mdl[2][3], 4'h0});
    get_entry(1, 3, v); check("R5 all-ones entry", v, 32'hFFFFFFF0);
  endtask

  task automatic t_bad_index();
    logic [31:0] v;
    put_entry(0, 6, 28'h1234567);
    put_entry(0, 7, 28'h7654321);
    for (int i = 0; i < NENT; i++) begin
      get_entry(0, i, v); check("R7 no update", v, {mdl[0][i], 4'h0});
    end
    wr(2, 32'hDEADBEE0);
    get_entry(0, 7, v); check("R7 read zero", v, 0);
    get_entry(0, 6, v); check("R7 read zero idx6", v, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(0, 32'h21);
    rd(0, v); check("R2 enable+mask", v, 32'h21);
    wr(0, 32'h80);
    rd(0, v); check("R2 force without enable", v, 0);
    check("R2 no restore", 32'(rs_valid), 0);
    tick();
    check("R2 no restore later", 32'(rs_valid), 0);
    wr(0, 32'h7E);
    rd(0, v); check("R2 mask only", v, 32'h7E);
    wr(0, 0);
  endtask

  task automatic t_restore(input logic [5:0] m);
    logic [31:0] v;
    logic [31:0] cw;
    cw = {24'd0, 1'b1, m, 1'b1};
    wr(0, cw);
    for (int k = 0; k < NENT; k++) begin
      rd(0, v); check("R3 force busy", v, cw);
      check("R4 index", 32'(rs_index), 32'(k));
      check("R4 valid", 32'(rs_valid), 32'(m[k]));
      if (m[k])
        for (int c = 0; c < NCH; c++)
          check("R4 data", 32'(rs_data[c*28 +: 28]), 32'(mdl[c][k]));
      if (k == 2) wr(0, 32'h0); else tick();
    end
    rd(0, v); check("R3 force cleared", v, {24'd0, 1'b0, m, 1'b1});
    check("R4 valid low after", 32'(rs_valid), 0);
  endtask

  task automatic t_go_in_restore();
    logic [31:0] v;
    wr(0, 32'h81 | (32'h3F << 1));
    tick();
    wr(2, 32'h5A5A5A50);
    wr(1, cmdw(1, 1, 1));
    wr(2, 32'h11111110);
    wr(1, cmdw(4, 0, 0));
    rd(1, v); check("R8 go held", v, cmdw(1, 1, 1));
    tick();
    rd(0, v); check("R8 restore ended", v & 32'h80, 0);
    rd(1, v); check("R8 go still held", v, cmdw(1, 1, 1));
    tick();
    rd(1, v); check("R8 go done", v, cmdw(1, 1, 0));
    mdl[0][1] = 28'h5A5A5A5;
    get_entry(0, 1, v); check("R8 ignored data write", v, 32'h5A5A5A50);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_access();
    t_bad_index();
    t_ctrl();
    t_restore(6'h10);
    t_restore(6'h3F);
    t_restore(6'h15);
    t_go_in_restore();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule